// File: doc/BRIEF.md
# SPI slave-select management unit

This unit owns the chip-select side of an SPI peripheral that can run as bus master or as slave. Two configuration bits pick one of three selection schemes. In the software scheme the peripheral's internal select is taken from a configuration bit and the select pad is ignored and left free. In the hardware-output scheme the unit drives the select pad itself. In the hardware-input scheme the pad is sampled as an input, which lets a slave be addressed and lets several masters share one bus.

In the hardware-output scheme the pad goes low at the first transfer the shift engine starts. It then stays low through any number of frames and idle gaps until the peripheral is disabled. A master whose effective select is pulled low by someone else raises a sticky mode fault. The fault drops the effective master and enable bits at once and holds until a clear pulse arrives while the cause is gone. A slave that is not selected tells the shift engine to ignore the serial clock and to release its data line. The pad input is resynchronised before use, and every output comes from a register on the system clock.

Top module: `ssel_mgr`

## Requirements
- R1: With `cfg_sw_sel`=1 the unit is in the software scheme. `sel_n` equals `cfg_int_sel` one clock after it is sampled, `nss_pad_in` has no effect on any output, and `nss_pad_oe` is 0.
- R2: With `cfg_sw_sel`=0, `cfg_int_sel` has no effect on any output.
- R3: `nss_pad_oe` is 1 one clock after `cfg_sw_sel`=0, `cfg_out_en`=1, `cfg_master`=1 and `cfg_enable`=1 are sampled with no mode fault pending, and 0 otherwise. In this hardware-output scheme `sel_n` reads 1.
- R4: In the hardware-output scheme `nss_pad_out` goes to 0 one clock after the first `xfer_start` pulse. It stays 0 across further pulses and idle cycles for as long as the R3 conditions hold, and returns to 1 one clock after they fail (for example on `cfg_enable`=0). Whenever `nss_pad_oe` is 0, `nss_pad_out` is 1.
- R5: With `cfg_sw_sel`=0 and `cfg_out_en`=0 (the hardware-input scheme), `sel_n` follows `nss_pad_in` three clocks later: two synchroniser stages plus the output register.
- R6: `slave_sel` is 1 one clock after the unit is enabled as a non-master with an effective select of 0. `slave_ignore` is 1 whenever `cfg_master` was 0 and `slave_sel` is 0, and 0 for a master.
- R7: An enabled master outside the hardware-output scheme whose effective select is 0 sets `mode_fault` one clock later. In that same clock `master_eff` and `enable_eff` go to 0.
- R8: `mode_fault` stays 1 until a `fault_clr` pulse is sampled while the fault cause is absent. A clear sampled in the same cycle as the cause leaves the fault set.
- R9: While `rst` is 1 the outputs read `sel_n`=1, `nss_pad_out`=1, `nss_pad_oe`=0, `slave_sel`=0, `slave_ignore`=1, `mode_fault`=0, `master_eff`=0 and `enable_eff`=0.
- R10: With no fault, `master_eff` and `enable_eff` equal `cfg_master` and `cfg_enable` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Peripheral enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_sw_sel | input | 1 | 1 = software selection scheme |
| cfg_int_sel | input | 1 | Internal select value used in the software scheme |
| cfg_out_en | input | 1 | Select-output enable for the hardware schemes |
| nss_pad_in | input | 1 | Select pad input, asynchronous |
| xfer_start | input | 1 | One-cycle pulse from the shift engine at the start of a transfer |
| fault_clr | input | 1 | Pulse that clears the mode fault |
| nss_pad_out | output | 1 | Select pad output level |
| nss_pad_oe | output | 1 | Select pad output enable |
| sel_n | output | 1 | Active-low internal select |
| slave_sel | output | 1 | Slave is selected |
| slave_ignore | output | 1 | Shift engine ignores the serial clock and releases its data line |
| mode_fault | output | 1 | Sticky mode fault |
| master_eff | output | 1 | Effective master bit after fault override |
| enable_eff | output | 1 | Effective enable bit after fault override |

## Verification
Two events can land on the same clock edge: the fault condition (an enabled master seeing its select go low) and the `fault_clr` pulse. The bench provokes this collision on purpose by keeping the select pad low while it pulses clear, and then expects the fault to remain set. Random stimulus also produces transfer strobes that arrive in the same cycle as the enable drops, and there the pad must go high rather than be driven low. Every cycle is judged against a bench model that is built from the requirements.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

    typedef enum logic [1:0] {
        MODE_SOFT   = 2'd0,
        MODE_HW_OUT = 2'd1,
        MODE_HW_IN  = 2'd2
    } sel_mode_e;

    typedef struct packed {
        logic sel_n;
        logic slave_sel;
        logic ignore;
        logic master;
        logic enable;
    } core_out_t;

    localparam core_out_t CORE_RESET = '{sel_n: 1'b1, slave_sel: 1'b0,
                                         ignore: 1'b1, master: 1'b0,
                                         enable: 1'b0};

    function automatic sel_mode_e pick_mode(input logic sw_sel, input logic out_en);
        if (sw_sel)
            return MODE_SOFT;
        else if (out_en)
            return MODE_HW_OUT;
        else
            return MODE_HW_IN;
    endfunction

endpackage

// File: rtl/ssel_sync.sv
module ssel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $display("ssel_sync: STAGES below 2 is not supported");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ssel_fault.sv
module ssel_fault (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic fault_q,
    output logic fault_d
);
    // set has priority over a clear in the same cycle
    assign fault_d = set_i | (fault_q & ~clr_i);

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= 1'b0;
        else
            fault_q <= fault_d;
    end

    // R8: held until a clear pulse
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !clr_i) |=> fault_q);

    // R7: condition always lands in the flag
    p_fault_set_r7: assert property (@(posedge clk) disable iff (rst)
        set_i |=> fault_q);
endmodule

// File: rtl/ssel_drive.sv
module ssel_drive (
    input  logic clk,
    input  logic rst,
    input  logic hw_ok,
    input  logic xfer_start,
    output logic pad_out,
    output logic pad_oe
);
    logic drive_q;
    logic drive_d;

    // latched low from the first transfer until the output scheme is left
    assign drive_d = hw_ok & (drive_q | xfer_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
            pad_out <= 1'b1;
            pad_oe  <= 1'b0;
        end else begin
            drive_q <= drive_d;
            pad_out <= ~drive_d;
            pad_oe  <= hw_ok;
        end
    end

    // R3: pad driven only after a valid output configuration
    p_oe_cfg_r3: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> $past(hw_ok));

    // R4: once low it holds while the scheme stays valid
    p_nss_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!pad_out && hw_ok) |=> !pad_out);

    // R4: undriven pad rests high
    p_nss_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
        !pad_oe |-> pad_out);
endmodule

// File: rtl/ssel_mgr.sv
module ssel_mgr
    import ssel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_enable,
    input  logic cfg_master,
    input  logic cfg_sw_sel,
    input  logic cfg_int_sel,
    input  logic cfg_out_en,
    input  logic nss_pad_in,
    input  logic xfer_start,
    input  logic fault_clr,
    output logic nss_pad_out,
    output logic nss_pad_oe,
    output logic sel_n,
    output logic slave_sel,
    output logic slave_ignore,
    output logic mode_fault,
    output logic master_eff,
    output logic enable_eff
);
    sel_mode_e mode;
    logic      nss_sync;
    logic      sel_raw;
    logic      fault_set;
    logic      fault_d;
    logic      hw_ok;
    core_out_t core_d;
    core_out_t core_q;

    ssel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (nss_pad_in),
        .dout (nss_sync)
    );

    assign mode = pick_mode(cfg_sw_sel, cfg_out_en);

    always_comb begin
        case (mode)
            MODE_SOFT:   sel_raw = cfg_int_sel;
            MODE_HW_OUT: sel_raw = 1'b1;
            default:     sel_raw = nss_sync;
        endcase
    end

    assign fault_set = cfg_enable & cfg_master & (mode != MODE_HW_OUT) & ~sel_raw;

    ssel_fault u_fault (
        .clk     (clk),
        .rst     (rst),
        .set_i   (fault_set),
        .clr_i   (fault_clr),
        .fault_q (mode_fault),
        .fault_d (fault_d)
    );

    assign hw_ok = (mode == MODE_HW_OUT) & cfg_master & cfg_enable & ~mode_fault;

    ssel_drive u_drive (
        .clk        (clk),
        .rst        (rst),
        .hw_ok      (hw_ok),
        .xfer_start (xfer_start),
        .pad_out    (nss_pad_out),
        .pad_oe     (nss_pad_oe)
    );

    always_comb begin
        core_d.sel_n     = sel_raw;
        core_d.slave_sel = cfg_enable & ~cfg_master & ~sel_raw;
        core_d.ignore    = ~cfg_master & ~core_d.slave_sel;
        core_d.master    = cfg_master & ~fault_d;
        core_d.enable    = cfg_enable & ~fault_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            core_q <= CORE_RESET;
        else
            core_q <= core_d;
    end

    assign sel_n        = core_q.sel_n;
    assign slave_sel    = core_q.slave_sel;
    assign slave_ignore = core_q.ignore;
    assign master_eff   = core_q.master;
    assign enable_eff   = core_q.enable;

    // R1: software scheme takes the configuration bit
    p_soft_select_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_sw_sel |=> (sel_n == $past(cfg_int_sel)));

    // R1: pad never driven in the software scheme
    p_soft_no_drive_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_sw_sel |=> !nss_pad_oe);

    // R7: a pending fault removes master and enable
    p_fault_forces_r7: assert property (@(posedge clk) disable iff (rst)
        mode_fault |-> (!master_eff && !enable_eff));

    // R6: a selected slave is never master and never ignores the clock
    p_slave_excl_r6: assert property (@(posedge clk) disable iff (rst)
        slave_sel |-> (!master_eff && !slave_ignore));
endmodule

// File: tb/ssel_mgr_tb.sv
module ssel_mgr_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 0, cfg_master = 0, cfg_sw_sel = 0, cfg_int_sel = 0, cfg_out_en = 0;
    logic nss_pad_in = 1, xfer_start = 0, fault_clr = 0;
    logic nss_pad_out, nss_pad_oe, sel_n, slave_sel, slave_ignore, mode_fault, master_eff, enable_eff;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ssel_mgr u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
        .cfg_sw_sel(cfg_sw_sel), .cfg_int_sel(cfg_int_sel), .cfg_out_en(cfg_out_en),
        .nss_pad_in(nss_pad_in), .xfer_start(xfer_start), .fault_clr(fault_clr),
        .nss_pad_out(nss_pad_out), .nss_pad_oe(nss_pad_oe), .sel_n(sel_n),
        .slave_sel(slave_sel), .slave_ignore(slave_ignore), .mode_fault(mode_fault),
        .master_eff(master_eff), .enable_eff(enable_eff)
    );

    // expected state, built from the requirements
    logic m_s1, m_s2, m_seln, m_slv, m_ign, m_fault, m_mst, m_en, m_drv, m_oe, m_out;

    function automatic logic eff_sel(logic sw, logic isel, logic oen, logic padsync);
        if (sw) return isel;
        if (oen) return 1'b1;
        return padsync;
    endfunction

    always @(posedge clk) begin : model
        logic raw, setc, fd, ok, dn, sl;
        raw  = eff_sel(cfg_sw_sel, cfg_int_sel, cfg_out_en, m_s2);
        setc = cfg_enable & cfg_master & ~(~cfg_sw_sel & cfg_out_en) & ~raw;
        fd   = setc | (m_fault & ~fault_clr);
        ok   = ~cfg_sw_sel & cfg_out_en & cfg_master & cfg_enable & ~m_fault;
        dn   = ok & (m_drv | xfer_start);
        sl   = cfg_enable & ~cfg_master & ~raw;
        if (rst) begin
            m_s1 <= 1; m_s2 <= 1; m_seln <= 1; m_slv <= 0; m_ign <= 1;
            m_fault <= 0; m_mst <= 0; m_en <= 0; m_drv <= 0; m_oe <= 0; m_out <= 1;
        end else begin
            m_s1 <= nss_pad_in; m_s2 <= m_s1; m_seln <= raw; m_slv <= sl;
            m_ign <= ~cfg_master & ~sl; m_fault <= fd;
            m_mst <= cfg_master & ~fd; m_en <= cfg_enable & ~fd;
            m_drv <= dn; m_oe <= ok; m_out <= ~dn;
        end
    end

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    logic last_sw;
    task automatic check_all();
        check(last_sw ? "R1" : "R5", "sel_n", sel_n, m_seln);
        check("R3", "nss_pad_oe", nss_pad_oe, m_oe);
        check("R4", "nss_pad_out", nss_pad_out, m_out);
        check("R6", "slave_sel", slave_sel, m_slv);
        check("R6", "slave_ignore", slave_ignore, m_ign);
        check("R7", "mode_fault", mode_fault, m_fault);
        check("R10", "master_eff", master_eff, m_mst);
        check("R10", "enable_eff", enable_eff, m_en);
    endtask

    task automatic step();
        last_sw = cfg_sw_sel;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic set_cfg(logic en, logic mst, logic sw, logic isel, logic oen);
        cfg_enable = en; cfg_master = mst; cfg_sw_sel = sw; cfg_int_sel = isel; cfg_out_en = oen;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset values
        check("R9", "sel_n", sel_n, 1'b1);
        check("R9", "nss_pad_out", nss_pad_out, 1'b1);
        check("R9", "nss_pad_oe", nss_pad_oe, 1'b0);
        check("R9", "slave_sel", slave_sel, 1'b0);
        check("R9", "slave_ignore", slave_ignore, 1'b1);
        check("R9", "mode_fault", mode_fault, 1'b0);
        check("R9", "master_eff", master_eff, 1'b0);
        check("R9", "enable_eff", enable_eff, 1'b0);
        rst = 0;
        step();

        // R2: hardware-input slave, internal bit toggled without effect
        set_cfg(1, 0, 0, 0, 0); nss_pad_in = 0;
        repeat (4) step();
        check("R5", "sel_n after pad low", sel_n, 1'b0);
        check("R6", "slave selected", slave_sel, 1'b1);
        cfg_int_sel = 1;
        repeat (2) step();
        check("R2", "sel_n with int bit 1", sel_n, 1'b0);
        check("R2", "slave_sel with int bit 1", slave_sel, 1'b1);
        nss_pad_in = 1;
        repeat (2) step();
        check("R5", "sel_n two clocks after pad high", sel_n, 1'b0);
        step();
        check("R5", "sel_n three clocks after pad high", sel_n, 1'b1);
        check("R6", "ignore when deselected", slave_ignore, 1'b1);

        // R1: software scheme ignores the pad
        set_cfg(1, 0, 1, 0, 0);
        step();
        check("R1", "soft select low", slave_sel, 1'b1);
        nss_pad_in = 0; repeat (3) step(); nss_pad_in = 1; repeat (3) step();
        check("R1", "pad ignored", sel_n, 1'b0);

        // R4: hardware output across frames and gaps until disable
        set_cfg(1, 1, 0, 0, 1);
        step();
        check("R3", "oe in output scheme", nss_pad_oe, 1'b1);
        check("R4", "high before first transfer", nss_pad_out, 1'b1);
        xfer_start = 1; step(); xfer_start = 0;
        check("R4", "low after first transfer", nss_pad_out, 1'b0);
        repeat (5) step();
        xfer_start = 1; step(); xfer_start = 0;
        repeat (7) step();
        check("R4", "still low after gaps", nss_pad_out, 1'b0);
        cfg_enable = 0; step();
        check("R4", "high after disable", nss_pad_out, 1'b1);
        check("R3", "oe off after disable", nss_pad_oe, 1'b0);

        // R7 and R8: fault set, clear, collision
        set_cfg(1, 1, 0, 0, 0); nss_pad_in = 0;
        repeat (4) step();
        check("R7", "fault raised", mode_fault, 1'b1);
        check("R7", "master dropped", master_eff, 1'b0);
        nss_pad_in = 1; repeat (4) step();
        check("R8", "fault held without clear", mode_fault, 1'b1);
        fault_clr = 1; step(); fault_clr = 0;
        check("R8", "fault cleared", mode_fault, 1'b0);
        check("R10", "master back", master_eff, 1'b1);
        nss_pad_in = 0; repeat (4) step();
        fault_clr = 1; step(); fault_clr = 0;
        check("R8", "set beats clear", mode_fault, 1'b1);
        nss_pad_in = 1; repeat (3) step();
        fault_clr = 1; step(); fault_clr = 0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 16) == 0)
                set_cfg(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
            if (($urandom % 4) == 0) nss_pad_in = $urandom % 2;
            xfer_start = (($urandom % 5) == 0);
            fault_clr  = (($urandom % 12) == 0);
            step();
        end
        xfer_start = 0; fault_clr = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule